// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Sequencer

This block is the host-side controller for a chain of 16-bit sampling converters that share one three-wire serial port. On a start request it raises the convert strobe while the serial clock is parked high, which puts every converter in the chain into chained mode with a ready indication. It then watches the serial data line from the converter nearest the host. A low-to-high transition on that line means every converter in the chain has finished converting.

On that transition the sequencer runs the serial clock for exactly 16×N+1 falling edges. The bit present before each falling edge is captured. The first captured bit is the ready flag and is dropped. The remaining 16×N bits arrive most-significant bit first, nearest converter first, and are packed into an N-word result bus. When the last clock is done, the convert strobe drops, the clock rests high, the bus updates and a one-cycle valid pulse is issued.

The serial clock half-period is set by a divider of the system clock. If the ready transition never comes, a timeout ends the sequence and raises an error flag.

Top module: `chain_reader`

## Requirements
- R1: After reset, cnv_o is 0, sck_o is 1, busy_o, valid_o and err_o are 0, and data_o is all zeros.
- R2: A start_i pulse seen while idle raises cnv_o and busy_o on the next clock edge, with sck_o still 1. cnv_o stays 1 until the sequence completes or times out. A start_i pulse seen while busy has no effect: it adds no clock edges and causes no extra valid pulse.
- R3: Only a low-to-high transition of sdo_i after cnv_o rises starts the readback. A line that is already high when the conversion starts holds the sequencer waiting, with sck_o high, until the line goes low and then high again.
- R4: One readback produces exactly 16×N_DEV+1 falling edges on sck_o. sck_o is 1 whenever cnv_o is 0.
- R5: Each sck_o low phase and high phase lasts D+1 system clocks, where D is the value of div_i sampled with the accepted start and is raised to 2 if it is smaller.
- R6: sdo_i is sampled just before each falling edge of sck_o, and the first sample is dropped. The next 16×N_DEV samples fill the words most-significant bit first. Word i (word 0 comes from the converter nearest the host) appears on data_o[16i+15:16i].
- R7: After the final low phase, sck_o returns to 1. In the same cycle cnv_o and busy_o fall, data_o takes the new words, and valid_o is 1 for exactly one cycle. data_o holds its value until the next completed readback.
- R8: If no ready transition arrives within TMO_CYC cycles of cnv_o rising, then cnv_o and busy_o fall after exactly TMO_CYC cycles high and err_o goes to 1. No valid pulse is issued and data_o is unchanged. err_o returns to 0 on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to start one conversion and readback |
| div_i | input | DIV_W | Serial clock half-period setting, sampled at start |
| sdo_i | input | 1 | Serial data from the nearest converter; acts as ready, then as data |
| cnv_o | output | 1 | Convert strobe to every converter in the chain |
| sck_o | output | 1 | Serial clock to every converter in the chain |
| data_o | output | 16×N_DEV | Result words; word 0 in the low 16 bits |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |
| busy_o | output | 1 | High from the accepted start until completion or timeout |
| err_o | output | 1 | Set by a ready timeout, cleared by the next start |

## Verification
The bench models a converter chain that shifts on each falling serial clock edge. It targets the cases where an off-by-one is easy to make. A sequencer that clocks 16×N edges instead of 16×N+1, or that keeps the ready bit, would return every word shifted by one bit. Swapping the nearest-first word order would put the words in the wrong slots. A sequencer that reacts to a level instead of a rising edge would start clocking while the line is still high from before the conversion. Other runs use a divider below the minimum and a start pulse in the middle of a readback, where a wrong clamp changes the measured half-period and a wrong ignore produces a second valid or extra edges. A silent chain checks that the timeout fires after exactly the set number of cycles and leaves the previous result intact.

// File: rtl/chain_reader_pkg.sv
package chain_reader_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // strobe low, clock parked high
    ST_WAIT = 2'd1,  // strobe high, waiting for ready edge
    ST_READ = 2'd2   // strobe high, serial clock running
  } rd_state_e;

endpackage

// File: rtl/chain_reader_sync.sv
// Multi-stage synchronizer for the incoming serial line plus rising-edge detect.
module chain_reader_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/chain_reader_sclk.sv
// Serial clock phase generator: parks high when not running, otherwise
// toggles every (half_i + 1) system clocks. Flags the cycle before each edge.
module chain_reader_sclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             fall_o,
  output logic             rise_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             at_end;

  assign at_end = (cnt_q == half_i);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (at_end) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = run_i & at_end & sck_q;
  assign rise_o = run_i & at_end & ~sck_q;

endmodule

// File: rtl/chain_reader_shift.sv
// Capture shift register: drops the first sample (ready flag), packs the
// rest MSB first, and reorders into nearest-first word slots on load.
module chain_reader_shift #(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    cap_i,
  input  logic                    bit_i,
  input  logic                    load_i,
  output logic [N_DEV*WORD_W-1:0] data_o
);

  localparam int TOT_W = N_DEV * WORD_W;

  logic [TOT_W-1:0] sr_q, sr_d;
  logic [TOT_W-1:0] dat_q, dat_d;
  logic [TOT_W-1:0] ordered;
  logic             first_q, first_d;

  // First captured word sits at the top of the shift register.
  for (genvar gi = 0; gi < N_DEV; gi++) begin : g_reorder
    assign ordered[gi*WORD_W +: WORD_W] = sr_q[(N_DEV-1-gi)*WORD_W +: WORD_W];
  end

  always_comb begin
    sr_d    = sr_q;
    first_d = first_q;
    dat_d   = dat_q;
    if (clr_i) begin
      first_d = 1'b1;
    end else if (cap_i) begin
      if (first_q) begin
        first_d = 1'b0;
      end else begin
        sr_d = {sr_q[TOT_W-2:0], bit_i};
      end
    end
    if (load_i) begin
      dat_d = ordered;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      first_q <= 1'b1;
      dat_q   <= '0;
    end else begin
      sr_q    <= sr_d;
      first_q <= first_d;
      dat_q   <= dat_d;
    end
  end

  assign data_o = dat_q;

endmodule

// File: rtl/chain_reader.sv
// Host-side sequencer for a daisy chain of 16-bit converters on one serial port.
module chain_reader #(
  parameter int N_DEV       = 3,
  parameter int WORD_W      = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_CYC     = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic                    sdo_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic [N_DEV*WORD_W-1:0] data_o,
  output logic                    valid_o,
  output logic                    busy_o,
  output logic                    err_o
);
  import chain_reader_pkg::*;

  localparam int TOTAL = N_DEV * WORD_W + 1;   // falling edges per readback
  localparam int FW    = $clog2(TOTAL + 1);
  localparam int TW    = $clog2(TMO_CYC + 1);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(SYNC_STAGES);

  rd_state_e        st_q, st_d;
  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic [TW-1:0]    tmo_q, tmo_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             cnv_q, cnv_d;
  logic             busy_q, busy_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             clr, cap, load;

  logic sdo_s, sdo_rise;
  logic run, sck_fall, sck_rise;

  chain_reader_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (sdo_i),
    .q_o    (sdo_s),
    .rise_o (sdo_rise)
  );

  assign run = (st_q == ST_READ);

  chain_reader_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .half_i (div_q),
    .sck_o  (sck_o),
    .fall_o (sck_fall),
    .rise_o (sck_rise)
  );

  chain_reader_shift #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .cap_i  (cap),
    .bit_i  (sdo_s),
    .load_i (load),
    .data_o (data_o)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    fcnt_d  = fcnt_q;
    tmo_d   = tmo_q;
    div_d   = div_q;
    cnv_d   = cnv_q;
    busy_d  = busy_q;
    err_d   = err_q;
    valid_d = 1'b0;
    clr     = 1'b0;
    cap     = 1'b0;
    load    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_WAIT;
          cnv_d  = 1'b1;
          busy_d = 1'b1;
          err_d  = 1'b0;
          tmo_d  = '0;
          fcnt_d = '0;
          clr    = 1'b1;
          div_d  = (div_i < MIN_DIV) ? MIN_DIV : div_i;
        end
      end
      ST_WAIT: begin
        if (sdo_rise) begin
          st_d = ST_READ;
        end else if (tmo_q == TW'(TMO_CYC - 1)) begin
          st_d   = ST_IDLE;
          cnv_d  = 1'b0;
          busy_d = 1'b0;
          err_d  = 1'b1;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      ST_READ: begin
        if (sck_fall) begin
          fcnt_d = fcnt_q + 1'b1;
          cap    = 1'b1;
        end
        if (sck_rise && (fcnt_q == FW'(TOTAL))) begin
          st_d    = ST_IDLE;
          cnv_d   = 1'b0;
          busy_d  = 1'b0;
          valid_d = 1'b1;
          load    = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        cnv_d  = 1'b0;
        busy_d = 1'b0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fcnt_q  <= '0;
      tmo_q   <= '0;
      div_q   <= MIN_DIV;
      cnv_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      fcnt_q  <= fcnt_d;
      tmo_q   <= tmo_d;
      div_q   <= div_d;
      cnv_q   <= cnv_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign cnv_o   = cnv_q;
  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

endmodule

// File: rtl/chain_reader_chk.sv
// Protocol checker bound to the sequencer top.
module chain_reader_chk #(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sck_o,
  input logic valid_o,
  input logic busy_o,
  input logic err_o
);

  localparam int TOTAL = N_DEV * WORD_W + 1;
  localparam int CW    = $clog2(TOTAL + 1) + 1;

  logic          sck_prev, cnv_prev;
  logic [CW-1:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b1;
      cnv_prev <= 1'b0;
      edges    <= '0;
    end else begin
      sck_prev <= sck_o;
      cnv_prev <= cnv_o;
      if (cnv_o && !cnv_prev) begin
        edges <= '0;
      end else if (!sck_o && sck_prev) begin
        edges <= edges + 1'b1;
      end
    end
  end

  // R2: the strobe rises only while the clock is parked high
  p_cnv_rise_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sck_o);

  // R2: the strobe only drops on completion or timeout
  p_cnv_fall_reason_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> (valid_o || err_o));

  // R4: clock high whenever the strobe is low
  p_sck_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_o |-> sck_o);

  // R4: exact edge count at completion
  p_edge_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (edges == CW'(TOTAL)));

  // R7: valid is a single cycle, coincident with strobe and busy falling
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($fell(cnv_o) && !busy_o));

  // R8: a timeout never produces a valid pulse
  p_err_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!valid_o && !cnv_o));

endmodule

bind chain_reader chain_reader_chk #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnv_o   (cnv_o),
  .sck_o   (sck_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .err_o   (err_o)
);

// File: tb/chain_reader_bench.sv
module chain_reader_bench;

  localparam int N     = 3;
  localparam int W     = 16;
  localparam int DW    = 8;
  localparam int TMO   = 400;
  localparam int BITS  = N * W;
  localparam int TOTAL = BITS + 1;

  logic            clk;
  logic            rst_n;
  logic            start_r;
  logic [DW-1:0]   div_r;
  logic            sdo_r;
  logic            cnv_o, sck_o, valid_o, busy_o, err_o;
  logic [BITS-1:0] data_o;

  chain_reader #(.N_DEV(N), .WORD_W(W), .DIV_W(DW), .TMO_CYC(TMO)) u_chain_reader (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_r),
    .div_i   (div_r),
    .sdo_i   (sdo_r),
    .cnv_o   (cnv_o),
    .sck_o   (sck_o),
    .data_o  (data_o),
    .valid_o (valid_o),
    .busy_o  (busy_o),
    .err_o   (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks;
  int failures;
  bit finished;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Chain model configuration
  logic [BITS-1:0] m_bus;
  int              m_dly;
  bit              m_pre;
  bit              m_silent;
  event            go_ev;

  // Scoreboard
  logic [BITS-1:0] exp_q[$];
  int              exp_half;
  logic [BITS-1:0] last_bus;

  // Monitor state
  logic mon_sck_prev, mon_cnv_prev;
  int   falls, low_run, first_low, cnv_hi;
  bit   got_first;

  // Converter chain model: ready edge, then one bit per falling sck edge
  initial begin
    sdo_r = 1'b0;
    forever begin
      @(go_ev);
      sdo_r = m_pre;
      @(posedge cnv_o);
      if (m_silent) begin
        wait (cnv_o == 1'b0);
        sdo_r = 1'b0;
      end else begin
        repeat (m_dly) @(posedge clk);
        if (m_pre) begin
          @(negedge clk);
          // R3: line high from before the start must not trigger readback
          chk(sck_o == 1'b1 && cnv_o == 1'b1 && busy_o == 1'b1, "R3 held-high line", {61'd0, sck_o, cnv_o, busy_o}, 64'h7);
          sdo_r = 1'b0;
          repeat (8) @(posedge clk);
        end
        sdo_r = 1'b1;
        for (int idx = 0; ; idx++) begin
          @(negedge sck_o or negedge cnv_o);
          if (!cnv_o) break;
          if (idx < BITS)
            sdo_r = m_bus[(idx / W) * W + (W - 1 - (idx % W))];
          else
            sdo_r = 1'b0;
        end
        sdo_r = 1'b0;
      end
    end
  end

  // Monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_sck_prev = 1'b1;
      mon_cnv_prev = 1'b0;
      falls = 0; low_run = 0; first_low = 0; cnv_hi = 0; got_first = 0;
    end else begin
      if (cnv_o && !mon_cnv_prev) begin
        falls = 0; low_run = 0; got_first = 0; cnv_hi = 0;
      end
      if (cnv_o) cnv_hi++;
      if (!sck_o && mon_sck_prev) falls++;
      if (!sck_o) low_run++;
      if (sck_o && !mon_sck_prev) begin
        if (!got_first) begin
          first_low = low_run;
          got_first = 1;
        end
        low_run = 0;
      end
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected valid", 64'd1, 64'd0);
        end else begin
          logic [BITS-1:0] e;
          e = exp_q.pop_front();
          chk(data_o == e, "R6 data words", 64'(data_o), 64'(e));
          chk(falls == TOTAL, "R4 falling edge count", 64'(falls), 64'(TOTAL));
          chk(first_low == exp_half, "R5 half period", 64'(first_low), 64'(exp_half));
          chk(!cnv_o && !busy_o && sck_o, "R7 end state", {61'd0, cnv_o, busy_o, sck_o}, 64'h1);
          last_bus = e;
        end
      end
      mon_sck_prev = sck_o;
      mon_cnv_prev = cnv_o;
    end
  end

  // Driver: pushes the expected result, then runs one sequence
  task automatic do_conv(input logic [BITS-1:0] bus, input int div, input int dly,
                         input bit pre, input bit silent, input bit restart);
    m_bus    = bus;
    m_dly    = dly;
    m_pre    = pre;
    m_silent = silent;
    exp_half = ((div < 2) ? 2 : div) + 1;
    if (!silent) exp_q.push_back(bus);
    -> go_ev;
    repeat (5) @(negedge clk);
    start_r = 1'b1;
    div_r   = DW'(div);
    @(negedge clk);
    start_r = 1'b0;
    div_r   = 8'd7;   // later changes must not matter (R5)
    chk(cnv_o && busy_o && sck_o && !err_o, "R2 start accepted", {60'd0, cnv_o, busy_o, sck_o, err_o}, 64'he);
    if (restart) begin
      repeat (120) @(negedge clk);
      start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!valid_o, "R7 valid single pulse", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    start_r = 1'b0; div_r = '0;
    last_bus = '0;
    m_bus = '0; m_dly = 0; m_pre = 0; m_silent = 0; exp_half = 3;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!cnv_o && sck_o && !busy_o && !valid_o && !err_o, "R1 reset outputs",
        {59'd0, cnv_o, sck_o, busy_o, valid_o, err_o}, 64'h8);
    chk(data_o == '0, "R1 reset data", 64'(data_o), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_conv(48'h1234_ABCD_8001, 2, 20, 0, 0, 0);
    do_conv(48'hFFFF_0000_5A5A, 0, 5, 0, 0, 0);    // R5 clamp of small divider
    do_conv(48'h8000_0001_C3C3, 5, 15, 1, 0, 0);   // R3 pre-high line
    // R8 timeout
    do_conv('0, 2, 0, 0, 1, 0);
    chk(err_o == 1'b1, "R8 error flag", {63'd0, err_o}, 64'd1);
    chk(cnv_hi == TMO, "R8 timeout length", 64'(cnv_hi), 64'(TMO));
    chk(data_o == last_bus, "R8 data unchanged", 64'(data_o), 64'(last_bus));
    // R2 restart ignored while busy; R8 error cleared by next start
    do_conv(48'h0F0F_7FFE_AAAA, 3, 10, 0, 0, 1);
    chk(err_o == 1'b0, "R8 error cleared", {63'd0, err_o}, 64'd0);
    do_conv(48'hFFFF_FFFF_FFFF, 2, 3, 0, 0, 0);
    chk(exp_q.size() == 0, "R7 all results delivered", 64'(exp_q.size()), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule